// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is an 8-bit down-counting timer fed by a 7-bit down-counting prescaler. Software reaches three byte-wide registers over a simple bus: a control/status register, the live counter and the live prescaler. A tick input advances the prescaler by one on each cycle in which it is high. A 3-bit select field sets how many ticks pass between two decrements of the counter.

When the counter steps down to 00h, a sticky zero flag is raised. The interrupt output is high while both that flag and an enable bit are set. A run bit starts and stops the timer. While the run bit is low, the prescaler is held at 7Fh and neither stage moves. A software write to the counter overrides a hardware decrement in the same cycle. If that decrement would have reached zero, the flag stays clear until the counter later reaches zero on its own.

Register addresses on `addr`: 0 is control, 1 is the counter, 2 is the prescaler, and 3 is unused and reads 00h. The control register layout, from bit 7 down to bit 0, is: zero flag, interrupt enable, constant 1, constant 0, run, and a 3-bit select in bits 2..0. Reads are combinational. Writes take effect at the clock edge where `wr_en` is high.

Top module: `tmr_top`

## Requirements
- R1: After reset, control reads 20h, the counter reads FFh, the prescaler reads 7Fh and `irq` is low.
- R2: Control reads back interrupt enable in bit 6, run in bit 3 and select in bits 2..0. Bit 5 always reads 1 and bit 4 always reads 0. Address 3 reads 00h.
- R3: While run is 0, the prescaler reads 7Fh, ticks do not change either stage, and writes to the prescaler are ignored. Writes to the counter still load it.
- R4: While run is 1, each tick decrements the prescaler by one, and it wraps from 00h to 7Fh.
- R5: With select value n and the prescaler starting at 7Fh, the counter first decrements on tick number 2^n. After that it decrements once every 2^n ticks.
- R6: A decrement from 01h to 00h sets the zero flag (control bit 7). The counter then wraps to FFh on its next decrement and keeps running, and the flag stays set.
- R7: Writing control with bit 7 = 0 clears the zero flag. Writing bit 7 = 1 never sets it. A zero arrival in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is high exactly when the zero flag and the interrupt enable are both 1.
- R9: A counter write in the same cycle as a decrement to 00h loads the written value and does not set the flag. The flag is set when the counter next reaches 00h.
- R10: A prescaler write while running loads bits 6..0 and takes priority over a same-cycle tick. Prescaler bit 7 always reads 0.
- R11: In cycles with `tick` low, neither the prescaler nor the counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler advance strobe |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. One is a counter write landing on the exact tick that would take the counter from 01h to 00h. The other is a clearing control write landing on the exact tick that sets the flag. The stimulus first loads the counter with 01h and selects division by 1, so the next tick is certain to be the zero arrival. It then raises `tick` and the write strobe in the same cycle. The division tests start each ratio from a stopped timer, so the prescaler phase is known, and they sample one tick before and one tick after each expected decrement.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_PSC  = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  // control register bit positions, decoded by software
  localparam int unsigned B_FLAG = 7;
  localparam int unsigned B_IEN  = 6;
  localparam int unsigned B_RUN  = 3;
  localparam int unsigned BUS_W  = 8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSC_W = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_q,
  input  logic             hold,
  input  logic             wr,
  input  logic [PSC_W-1:0] wdata,
  input  logic [SEL_W-1:0] sel,
  output logic [PSC_W-1:0] psc,
  output logic             step
);
  localparam logic [PSC_W-1:0] TOP = {PSC_W{1'b1}};

  // low bits that must be zero before a tick counts as a counter step
  function automatic logic [PSC_W-1:0] low_mask(input logic [SEL_W-1:0] s);
    return PSC_W'((33'd1 << s) - 33'd1);
  endfunction

  assign step = tick && run_q && ((psc & low_mask(sel)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             psc <= TOP;
    else if (hold)          psc <= TOP;
    else if (wr)            psc <= wdata;
    else if (tick && run_q) psc <= psc - 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // a write in the same cycle masks the arrival at zero
  assign zero_evt = step && !wr && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '1;
    else if (wr)   cnt <= wdata;
    else if (step) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl #(
  parameter int unsigned SEL_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [tmr_pkg::BUS_W-1:0]  wdata,
  input  logic                       zero_evt,
  output logic                       flag,
  output logic                       ien,
  output logic                       run,
  output logic                       run_nxt,
  output logic [SEL_W-1:0]           sel,
  output logic                       clr_req
);
  import tmr_pkg::*;

  assign clr_req = wr && !wdata[B_FLAG];
  assign run_nxt = wr ? wdata[B_RUN] : run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= 1'b0;
      run <= 1'b0;
      sel <= '0;
    end else if (wr) begin
      ien <= wdata[B_IEN];
      run <= wdata[B_RUN];
      sel <= wdata[SEL_W-1:0];
    end
  end

  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (zero_evt) flag <= 1'b1;
    else if (clr_req)  flag <= 1'b0;
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PSC_W = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  import tmr_pkg::*;

  logic             ctrl_wr, cnt_wr, psc_wr;
  logic             flag, ien, run, run_nxt, clr_req;
  logic [SEL_W-1:0] sel;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cnt;
  logic             step, zero_evt;
  logic [7:0]       ctrl_rd;

  assign ctrl_wr = wr_en && (addr == REG_CTRL);
  assign cnt_wr  = wr_en && (addr == REG_CNT);
  assign psc_wr  = wr_en && (addr == REG_PSC);

  tmr_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(wdata),
    .zero_evt(zero_evt), .flag(flag), .ien(ien), .run(run),
    .run_nxt(run_nxt), .sel(sel), .clr_req(clr_req)
  );

  tmr_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_q(run), .hold(!run_nxt),
    .wr(psc_wr), .wdata(wdata[PSC_W-1:0]), .sel(sel), .psc(psc), .step(step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .wr(cnt_wr),
    .wdata(wdata[CNT_W-1:0]), .cnt(cnt), .zero_evt(zero_evt)
  );

  always_comb begin
    ctrl_rd = 8'h20;
    ctrl_rd[B_FLAG] = flag;
    ctrl_rd[B_IEN]  = ien;
    ctrl_rd[B_RUN]  = run;
    ctrl_rd[SEL_W-1:0] = sel;
  end

  always_comb begin
    unique case (addr)
      REG_CTRL: rdata = ctrl_rd;
      REG_CNT:  rdata = 8'(cnt);
      REG_PSC:  rdata = 8'(psc);
      default:  rdata = 8'h00;
    endcase
  end

  assign irq = flag && ien;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PSC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             ien,
  input logic             flag,
  input logic             irq,
  input logic             clr_req,
  input logic             zero_evt,
  input logic             step,
  input logic             cnt_wr,
  input logic [7:0]       wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [PSC_W-1:0] psc
);
  assert_psc_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> psc == {PSC_W{1'b1}});

  assert_cnt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_step_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> tick);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);

  assert_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata[CNT_W-1:0]));
endmodule

bind tmr_top tmr_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .ien(ien), .flag(flag),
  .irq(irq), .clr_req(clr_req), .zero_evt(zero_evt), .step(step),
  .cnt_wr(cnt_wr), .wdata(wdata), .cnt(cnt), .psc(psc)
);

// File: tb/sim_tmr_top.sv
module sim_tmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int         errors = 0;
  int         checks = 0;
  logic [7:0] v;

  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_PSC = 2'd2, A_NONE = 2'd3;

  tmr_top u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
              .wdata(wdata), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset;
    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h20);
    rd(A_CNT, v);  chk("R1 cnt", v, 8'hFF);
    rd(A_PSC, v);  chk("R1 psc", v, 8'h7F);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_map;
    wr(A_CTRL, 8'h4D);
    rd(A_CTRL, v); chk("R2 fields", v, 8'h6D);
    wr(A_CTRL, 8'hD0);
    rd(A_CTRL, v); chk("R2/R7 bit4 and bit7 write", v, 8'h60);
    rd(A_NONE, v); chk("R2 unused addr", v, 8'h00);
  endtask

  task automatic t_hold;
    wr(A_CTRL, 8'h20);
    wr(A_CNT, 8'h10);
    ticks(20);
    rd(A_CNT, v); chk("R3 cnt frozen", v, 8'h10);
    rd(A_PSC, v); chk("R3 psc held", v, 8'h7F);
    wr(A_PSC, 8'h33);
    rd(A_PSC, v); chk("R3 psc write ignored", v, 8'h7F);
  endtask

  task automatic t_psc;
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h08);
    ticks(5);
    rd(A_PSC, v); chk("R4 psc count", v, 8'h7A);
    wr(A_PSC, 8'h81);
    rd(A_PSC, v); chk("R10 psc load bit7 zero", v, 8'h01);
    ticks(2);
    rd(A_PSC, v); chk("R4 psc wrap", v, 8'h7F);
    // R10: write and tick in the same cycle, write wins
    @(negedge clk); addr = A_PSC; wdata = 8'h40; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(A_PSC, v); chk("R10 write beats tick", v, 8'h40);
  endtask

  task automatic t_notick;
    rd(A_PSC, v);
    repeat (10) @(negedge clk);
    begin
      logic [7:0] p;
      rd(A_PSC, p); chk("R11 psc idle", p, v);
    end
  endtask

  task automatic t_div(input int n);
    int period;
    period = 1 << n;
    wr(A_CTRL, 8'h00);
    wr(A_CNT, 8'h50);
    wr(A_CTRL, 8'h08 | 8'(n));
    if (period > 1) begin
      ticks(period - 1);
      rd(A_CNT, v); chk("R5 before first step", v, 8'h50);
      ticks(1);
    end else begin
      ticks(1);
    end
    rd(A_CNT, v); chk("R5 first step", v, 8'h4F);
    ticks(period);
    rd(A_CNT, v); chk("R5 second step", v, 8'h4E);
  endtask

  task automatic t_zero;
    wr(A_CTRL, 8'h00);
    wr(A_CNT, 8'h02);
    wr(A_CTRL, 8'h48);
    ticks(1);
    rd(A_CTRL, v); chk("R6 no flag yet", v, 8'h68);
    chk("R8 irq low", {7'd0, irq}, 8'h00);
    ticks(1);
    rd(A_CNT, v);  chk("R6 at zero", v, 8'h00);
    rd(A_CTRL, v); chk("R6 flag set", v, 8'hE8);
    chk("R8 irq high", {7'd0, irq}, 8'h01);
    ticks(1);
    rd(A_CNT, v);  chk("R6 wrap", v, 8'hFF);
    rd(A_CTRL, v); chk("R6 flag sticky", v, 8'hE8);
    wr(A_CTRL, 8'h08);
    rd(A_CTRL, v); chk("R7 flag cleared", v, 8'h28);
    chk("R8 irq off", {7'd0, irq}, 8'h00);
    wr(A_CNT, 8'h01);
    ticks(1);
    rd(A_CTRL, v); chk("R6 flag with ien 0", v, 8'hA8);
    chk("R8 irq masked", {7'd0, irq}, 8'h00);
    wr(A_CTRL, 8'hC8);
    chk("R8 irq enabled", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_collide;
    wr(A_CTRL, 8'h00);
    wr(A_CNT, 8'h01);
    wr(A_CTRL, 8'h08);
    @(negedge clk); addr = A_CNT; wdata = 8'h05; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(A_CNT, v);  chk("R9 write loaded", v, 8'h05);
    rd(A_CTRL, v); chk("R9 flag suppressed", v, 8'h28);
    ticks(5);
    rd(A_CTRL, v); chk("R9 flag on next zero", v, 8'hA8);
  endtask

  task automatic t_setclr;
    wr(A_CTRL, 8'h00);
    wr(A_CNT, 8'h01);
    wr(A_CTRL, 8'h08);
    @(negedge clk); addr = A_CTRL; wdata = 8'h08; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(A_CTRL, v); chk("R7 set beats clear", v, 8'hA8);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_hold();
    t_psc();
    t_notick();
    t_div(0);
    t_div(3);
    t_div(7);
    t_zero();
    t_collide();
    t_setclr();
    finish_run();
  end
endmodule